// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Recency Replacement

This block caches virtual-to-physical page mappings in a small, fully associative array. Each slot holds a virtual base, a physical base, a page size given as a base-2 logarithm, and four attribute flags: writable, user-accessible, global and uncacheable. A lookup compares the request address against the address range of every live slot in parallel. On a hit it forms the physical address and checks page permissions for the requesting privilege level. It then returns hit, fault, fault-as-write, uncacheable and the physical address in a registered response one cycle after the request is accepted. A miss is only reported. Page walking and refill are handled elsewhere.

Replacement follows recency. An insert uses a free slot if one exists. Otherwise it evicts the least recently used slot. The new slot becomes the most recent. A lookup promotes the slot it hits only when the requester asks for it. Maintenance inputs can invalidate every slot, invalidate only non-global slots, or drop the single slot that covers a given address. Each maintenance operation completes in one clock.

The lookup path uses valid/ready handshakes on both sides. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in any cycle where a maintenance input is asserted. It is also low while a response is pending that the consumer has not taken (`rsp_valid` high with `rsp_ready` low). A pending response holds all its fields stable until it is taken. The maintenance and insert inputs are plain one-cycle strobes and are always taken.

Top module: `va_xlat_buffer`

## Requirements
- R1: A live slot matches address `va` when `vbase <= va` and `va < vbase + 2**shift`. Here `shift` is the stored page-size field, giving a size of `2**shift` bytes.
- R2: On a hit, `rsp_pa` = `pbase | (va & (2**shift - 1))` and `rsp_nc` equals the slot's uncacheable flag, whether or not the access faults. On a miss, `rsp_hit`, `rsp_fault`, `rsp_fault_wr`, `rsp_nc` and `rsp_pa` are all zero.
- R3: An insert writes a free slot when one exists and evicts nothing. When all slots are live, it replaces the least recently used slot. The written slot becomes the most recently used.
- R4: A hitting lookup with `req_touch`=1 makes the hit slot the most recently used. With `req_touch`=0 the recency order is unchanged.
- R5: When several live slots match, the most recently used of them supplies the result.
- R6: `flush_all` invalidates every slot. `flush_nonglobal` invalidates exactly the slots whose global flag is 0.
- R7: `demap_en` invalidates the slot that a lookup of `demap_va` would select (per R5). The recency order of the other slots is unchanged.
- R8: The access is user-level when `req_cpl` equals 3 and `req_ovr` is 0. A write is illegal when the slot is not writable and either the access is user-level or `wp_en` is 1. A hit faults when a user-level access meets a slot whose user flag is 0, when `req_write` is 1 and the write is illegal, or when `req_stchk` is 1 and the write would be illegal.
- R9: On a fault, `rsp_fault_wr` is 1 when `req_write` is 1. It is also 1 when the fault comes only from the store-check condition, with the user-level check not firing. Otherwise it is 0. `rsp_fault_wr` is never 1 without `rsp_fault`.
- R10: At most one maintenance operation takes effect per cycle, in this priority: `flush_all`, `flush_nonglobal`, `demap_en`, `ins_en`. Lower-priority strobes in the same cycle are dropped.
- R11: `req_ready` is 0 in any cycle with a maintenance strobe, and while `rsp_valid`=1 with `rsp_ready`=0. The response is registered and appears in the cycle after acceptance. A held response keeps every field stable.
- R12: After reset no slot is live, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_en | input | 1 | Write-protect control: supervisor writes to read-only pages fault |
| flush_all | input | 1 | Invalidate every slot |
| flush_nonglobal | input | 1 | Invalidate slots whose global flag is clear |
| demap_en | input | 1 | Invalidate the slot covering `demap_va` |
| demap_va | input | VA_W | Address for single-page removal |
| ins_en | input | 1 | Insert strobe |
| ins_vbase | input | VA_W | Virtual base of new slot (aligned to its size) |
| ins_pbase | input | PA_W | Physical base of new slot (aligned to its size) |
| ins_shift | input | SH_W | Base-2 logarithm of page size |
| ins_wr | input | 1 | Writable flag |
| ins_user | input | 1 | User-accessible flag |
| ins_glob | input | 1 | Global flag |
| ins_nc | input | 1 | Uncacheable flag |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_va | input | VA_W | Lookup address |
| req_write | input | 1 | Access is a write |
| req_stchk | input | 1 | Store-check request: check as if writing |
| req_cpl | input | 2 | Requesting privilege level |
| req_ovr | input | 1 | Supervisor override: never treat as user-level |
| req_touch | input | 1 | Promote the hit slot to most recent |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | A slot matched |
| rsp_fault | output | 1 | Page permission fault |
| rsp_fault_wr | output | 1 | Fault reported as a write access |
| rsp_nc | output | 1 | Hit slot is uncacheable |
| rsp_pa | output | PA_W | Translated physical address |

## Verification
The assertions assume the following about the inputs. Inserted virtual and physical bases are aligned to their own page size. The size field stays below the address width, so a range end fits one extra bit. The response consumer never changes its mind about a response that is not offered. With those assumptions, the matcher's winner vector stays one-hot or empty, and the recency matrix stays a strict total order. The stimulus inserts only 4 KiB and 2 MiB pages at aligned bases. It drives lookups only through the handshake, and it holds `rsp_ready` low only to check the hold behaviour. The stimulus deliberately overlaps a small page inside a large one, so that the recency rules of R5 and R7 decide the result.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WIPE_ALL,
    OP_WIPE_LOCAL,
    OP_DROP_PAGE,
    OP_FILL
  } maint_op_e;

  // user-level access: lowest privilege and no supervisor override
  function automatic logic user_mode(input logic [1:0] cpl, input logic ovr);
    return (cpl == 2'd3) && !ovr;
  endfunction

  // one maintenance operation per cycle, fixed priority (R10)
  function automatic maint_op_e pick_op(input logic fa, input logic fng,
                                        input logic dm, input logic ins);
    if (fa)       return OP_WIPE_ALL;
    else if (fng) return OP_WIPE_LOCAL;
    else if (dm)  return OP_DROP_PAGE;
    else if (ins) return OP_FILL;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/xlat_age_matrix.sv
module xlat_age_matrix #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_en,
  input  logic [IW-1:0]   touch_idx,
  output logic [N*N-1:0]  newer_o,
  output logic [IW-1:0]   lru_idx
);

  // newer_q[i][j] = 1: slot i was used more recently than slot j
  logic [N-1:0] newer_q [N];
  logic [N-1:0] lru_vec;
  logic         anti_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          newer_q[i][j] <= (i > j);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (IW'(i) == touch_idx && i != j)
            newer_q[i][j] <= 1'b1;
          else if (IW'(j) == touch_idx && i != j)
            newer_q[i][j] <= 1'b0;
        end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lru_vec[i] = ~|newer_q[i];
      for (int j = 0; j < N; j++)
        newer_o[i*N + j] = newer_q[i][j];
    end
    lru_idx = '0;
    for (int i = 0; i < N; i++)
      if (lru_vec[i]) lru_idx = IW'(i);
  end

  always_comb begin
    anti_ok = 1'b1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && (newer_q[i][j] == newer_q[j][i])) anti_ok = 1'b0;
  end

  // R4
  order_antisym_chk: assert property (@(posedge clk) disable iff (!rst_n) anti_ok);

  // R3
  lru_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(lru_vec));

endmodule

// File: rtl/xlat_range_match.sv
module xlat_range_match #(
  parameter int N    = 8,
  parameter int VA_W = 32,
  parameter int SH_W = 5,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  va,
  input  logic [N*VA_W-1:0] vbase_flat,
  input  logic [N*SH_W-1:0] shift_flat,
  input  logic [N-1:0]     live,
  input  logic [N*N-1:0]   newer_flat,
  output logic             hit,
  output logic [IW-1:0]    idx
);

  logic [N-1:0] inrng;
  logic [N-1:0] win;

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [VA_W-1:0] base;
    logic [SH_W-1:0] sh;
    logic [VA_W:0]   lim;
    assign base = vbase_flat[e*VA_W +: VA_W];
    assign sh   = shift_flat[e*SH_W +: SH_W];
    assign lim  = {1'b0, base} + ((VA_W+1)'(1) << sh);
    // R1: half-open range test
    assign inrng[e] = live[e] && (va >= base) && ({1'b0, va} < lim);
  end

  // R5: a matching slot wins only if it is newer than every other match
  always_comb begin
    for (int i = 0; i < N; i++) begin
      win[i] = inrng[i];
      for (int j = 0; j < N; j++)
        if (!((i == j) || !inrng[j] || newer_flat[i*N + j])) win[i] = 1'b0;
    end
    idx = '0;
    for (int i = 0; i < N; i++)
      if (win[i]) idx = IW'(i);
  end

  assign hit = |inrng;

  // R5
  mru_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win) && (hit == (|win)));

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic       pg_wr,
  input  logic       pg_usr,
  input  logic [1:0] cpl,
  input  logic       ovr,
  input  logic       wr,
  input  logic       stchk,
  input  logic       wp,
  output logic       fault,
  output logic       fault_wr
);

  logic usr_acc, bad_wr, priv_viol, wr_viol, sc_viol;

  // R8
  assign usr_acc   = user_mode(cpl, ovr);
  assign bad_wr    = !pg_wr && (usr_acc || wp);
  assign priv_viol = usr_acc && !pg_usr;
  assign wr_viol   = wr && bad_wr;
  assign sc_viol   = stchk && bad_wr;
  assign fault     = priv_viol || wr_viol || sc_viol;
  // R9: write accesses report as writes; a store-check fault reports as a
  // write only when the privilege check did not already claim it
  assign fault_wr  = wr ? fault : (!priv_viol && sc_viol);

endmodule

// File: rtl/va_xlat_buffer.sv
module va_xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SH_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_en,
  input  logic             flush_all,
  input  logic             flush_nonglobal,
  input  logic             demap_en,
  input  logic [VA_W-1:0]  demap_va,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_vbase,
  input  logic [PA_W-1:0]  ins_pbase,
  input  logic [SH_W-1:0]  ins_shift,
  input  logic             ins_wr,
  input  logic             ins_user,
  input  logic             ins_glob,
  input  logic             ins_nc,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_stchk,
  input  logic [1:0]       req_cpl,
  input  logic             req_ovr,
  input  logic             req_touch,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_fault_wr,
  output logic             rsp_nc,
  output logic [PA_W-1:0]  rsp_pa
);

  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [VA_W-1:0] vbase_q [N_ENTRIES];
  logic [PA_W-1:0] pbase_q [N_ENTRIES];
  logic [SH_W-1:0] shift_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] valid_q, wr_q, usr_q, glob_q, nc_q;

  logic [N_ENTRIES*VA_W-1:0] vb_flat;
  logic [N_ENTRIES*SH_W-1:0] sh_flat;
  logic [N_ENTRIES*N_ENTRIES-1:0] newer;

  logic [IW-1:0] lru_idx, free_idx, fill_idx, lk_idx, dm_idx, touch_idx;
  logic          lk_hit, dm_hit, touch_en, accept;
  logic          pf, pfw;
  logic [VA_W-1:0] off_mask;
  logic [PA_W-1:0] pa_calc;
  maint_op_e     op;

  always_comb begin
    for (int e = 0; e < N_ENTRIES; e++) begin
      vb_flat[e*VA_W +: VA_W] = vbase_q[e];
      sh_flat[e*SH_W +: SH_W] = shift_q[e];
    end
  end

  // ---------------------------------------------------------------- control
  assign op        = pick_op(flush_all, flush_nonglobal, demap_en, ins_en);
  // R11
  assign req_ready = (op == OP_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  // ---------------------------------------------------------------- match
  xlat_range_match #(.N(N_ENTRIES), .VA_W(VA_W), .SH_W(SH_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .va(req_va), .vbase_flat(vb_flat),
    .shift_flat(sh_flat), .live(valid_q), .newer_flat(newer),
    .hit(lk_hit), .idx(lk_idx)
  );

  xlat_range_match #(.N(N_ENTRIES), .VA_W(VA_W), .SH_W(SH_W)) u_dm_match (
    .clk(clk), .rst_n(rst_n), .va(demap_va), .vbase_flat(vb_flat),
    .shift_flat(sh_flat), .live(valid_q), .newer_flat(newer),
    .hit(dm_hit), .idx(dm_idx)
  );

  // ---------------------------------------------------------------- recency
  always_comb begin
    free_idx = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--)
      if (!valid_q[e]) free_idx = IW'(e);
  end

  // R3: free slot first, least recent otherwise
  assign fill_idx  = (&valid_q) ? lru_idx : free_idx;
  // R3 / R4: insert and promoting lookup never share a cycle (R11)
  assign touch_en  = (op == OP_FILL) || (accept && req_touch && lk_hit);
  assign touch_idx = (op == OP_FILL) ? fill_idx : lk_idx;

  xlat_age_matrix #(.N(N_ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .newer_o(newer), .lru_idx(lru_idx)
  );

  // ---------------------------------------------------------------- storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      case (op)
        OP_WIPE_ALL:   valid_q <= '0;
        OP_WIPE_LOCAL: valid_q <= valid_q & glob_q;
        OP_DROP_PAGE:  if (dm_hit) valid_q[dm_idx] <= 1'b0;
        OP_FILL:       valid_q[fill_idx] <= 1'b1;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_FILL) begin
      vbase_q[fill_idx] <= ins_vbase;
      pbase_q[fill_idx] <= ins_pbase;
      shift_q[fill_idx] <= ins_shift;
      wr_q[fill_idx]    <= ins_wr;
      usr_q[fill_idx]   <= ins_user;
      glob_q[fill_idx]  <= ins_glob;
      nc_q[fill_idx]    <= ins_nc;
    end
  end

  // ---------------------------------------------------------------- result
  xlat_perm_check u_perm (
    .pg_wr(wr_q[lk_idx]), .pg_usr(usr_q[lk_idx]), .cpl(req_cpl),
    .ovr(req_ovr), .wr(req_write), .stchk(req_stchk), .wp(wp_en),
    .fault(pf), .fault_wr(pfw)
  );

  // R2
  assign off_mask = (VA_W'(1) << shift_q[lk_idx]) - VA_W'(1);
  assign pa_calc  = pbase_q[lk_idx] | PA_W'(req_va & off_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_fault_wr <= 1'b0;
      rsp_nc       <= 1'b0;
      rsp_pa       <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_hit      <= lk_hit;
      rsp_fault    <= lk_hit && pf;
      rsp_fault_wr <= lk_hit && pfw;
      rsp_nc       <= lk_hit && nc_q[lk_idx];
      rsp_pa       <= lk_hit ? pa_calc : '0;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  // ---------------------------------------------------------------- checks
  // R6
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  // R6
  wipe_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_nonglobal && !flush_all) |=> ((valid_q & ~glob_q) == '0));

  // R3
  fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !flush_all && !flush_nonglobal && !demap_en && !(&valid_q))
    |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R3
  fill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !flush_all && !flush_nonglobal && !demap_en && (&valid_q))
    |=> (&valid_q));

  // R7
  drop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (demap_en && !flush_all && !flush_nonglobal && dm_hit)
    |=> ($countones(valid_q) == $past($countones(valid_q)) - 1));

  // R11
  maint_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_nonglobal || demap_en || ins_en) |-> !req_ready);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_hit) && $stable(rsp_fault) && $stable(rsp_fault_wr) &&
      $stable(rsp_nc)));

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_fault && !rsp_fault_wr && !rsp_nc &&
      (rsp_pa == '0)));

  // R9
  fault_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault_wr) |-> rsp_fault);

endmodule

// File: tb/va_xlat_buffer_test.sv
`timescale 1ns/1ps
module va_xlat_buffer_test;

  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic wp_en = 0, flush_all = 0, flush_nonglobal = 0, demap_en = 0, ins_en = 0;
  logic [31:0] demap_va = 0, ins_vbase = 0, ins_pbase = 0, req_va = 0;
  logic [4:0]  ins_shift = 0;
  logic ins_wr = 0, ins_user = 0, ins_glob = 0, ins_nc = 0;
  logic req_valid = 0, req_ready, req_write = 0, req_stchk = 0, req_ovr = 0, req_touch = 0;
  logic [1:0] req_cpl = 0;
  logic rsp_valid, rsp_ready = 1, rsp_hit, rsp_fault, rsp_fault_wr, rsp_nc;
  logic [31:0] rsp_pa;

  int checks = 0, fails = 0;
  logic [35:0] exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  va_xlat_buffer #(.N_ENTRIES(N), .VA_W(32), .PA_W(32), .SH_W(5)) uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: issue one lookup and push its expected result
  task automatic look(input logic [31:0] va, input logic [1:0] cpl, input logic ovr,
                      input logic wr, input logic sc, input logic tch,
                      input logic eh, input logic ef, input logic ew, input logic en,
                      input logic [31:0] epa, input string tag);
    req_va = va; req_cpl = cpl; req_ovr = ovr; req_write = wr;
    req_stchk = sc; req_touch = tch; req_valid = 1;
    exp_q.push_back({eh, ef, ew, en, epa});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0; req_touch = 0; req_write = 0; req_stchk = 0; req_ovr = 0;
  endtask

  task automatic miss(input logic [31:0] va, input string tag);
    look(va, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, tag);
  endtask

  task automatic hit_rd(input logic [31:0] va, input logic tch, input logic en,
                        input logic [31:0] epa, input string tag);
    look(va, 2'd0, 0, 0, 0, tch, 1, 0, 0, en, epa, tag);
  endtask

  task automatic maint(input logic fa, input logic fng, input logic dm,
                       input logic [31:0] dva, input logic ie,
                       input logic [31:0] vb, input logic [31:0] pb, input logic [4:0] sh,
                       input logic w, input logic u, input logic g, input logic n);
    flush_all = fa; flush_nonglobal = fng; demap_en = dm; demap_va = dva;
    ins_en = ie; ins_vbase = vb; ins_pbase = pb; ins_shift = sh;
    ins_wr = w; ins_user = u; ins_glob = g; ins_nc = n;
    #1 chk(req_ready == 1'b0, "R11", "ready during maintenance", {31'b0, req_ready}, 32'h0);
    @(posedge clk); #1;
    flush_all = 0; flush_nonglobal = 0; demap_en = 0; ins_en = 0;
  endtask

  task automatic put(input logic [31:0] vb, input logic [31:0] pb, input logic [4:0] sh,
                     input logic w, input logic u, input logic g, input logic n);
    maint(0, 0, 0, 32'h0, 1, vb, pb, sh, w, u, g, n);
  endtask

  // monitor: pop and compare each taken response
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected response", rsp_pa, 32'h0);
        end else begin
          logic [35:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({rsp_hit, rsp_fault, rsp_fault_wr, rsp_nc} == e[35:32], t,
              "hit/fault/fault_wr/nc", {28'b0, rsp_hit, rsp_fault, rsp_fault_wr, rsp_nc},
              {28'b0, e[35:32]});
          chk(rsp_pa == e[31:0], t, "pa", rsp_pa, e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R12
    chk(rsp_valid == 0, "R12", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk(req_ready == 1, "R12", "req_ready after reset", {31'b0, req_ready}, 32'h1);
    @(posedge clk); #1;
    miss(32'h0000_1000, "R12");

    // R1 / R2: one 4 KiB page, writable, user
    put(32'h0001_0000, 32'h0008_0000, 5'd12, 1, 1, 0, 0);
    look(32'h0001_0abc, 2'd3, 0, 0, 0, 0, 1, 0, 0, 0, 32'h0008_0abc, "R2");
    look(32'h0001_0fff, 2'd3, 0, 1, 0, 0, 1, 0, 0, 0, 32'h0008_0fff, "R1");
    miss(32'h0001_1000, "R1");
    miss(32'h0000_ffff, "R1");

    // 2 MiB page: read-only, supervisor, global, uncacheable
    put(32'h0040_0000, 32'h0200_0000, 5'd21, 0, 0, 1, 1);
    hit_rd(32'h0045_6789, 0, 1, 32'h0205_6789, "R2");
    look(32'h0045_6789, 2'd3, 0, 0, 0, 0, 1, 1, 0, 1, 32'h0205_6789, "R8");
    look(32'h0045_6789, 2'd3, 1, 0, 0, 0, 1, 0, 0, 1, 32'h0205_6789, "R8");
    look(32'h0045_6789, 2'd0, 0, 1, 0, 0, 1, 0, 0, 1, 32'h0205_6789, "R8");
    look(32'h0045_6789, 2'd3, 1, 1, 0, 0, 1, 0, 0, 1, 32'h0205_6789, "R8");
    wp_en = 1;
    look(32'h0045_6789, 2'd0, 0, 1, 0, 0, 1, 1, 1, 1, 32'h0205_6789, "R9");
    look(32'h0045_6789, 2'd0, 0, 0, 1, 0, 1, 1, 1, 1, 32'h0205_6789, "R9");
    wp_en = 0;
    look(32'h0045_6789, 2'd3, 0, 0, 1, 0, 1, 1, 0, 1, 32'h0205_6789, "R9");

    // R5 / R4: small page inside the large one
    put(32'h0040_0000, 32'h0300_0000, 5'd12, 1, 1, 0, 0);
    hit_rd(32'h0040_0123, 0, 0, 32'h0300_0123, "R5");
    hit_rd(32'h0045_0000, 0, 1, 32'h0205_0000, "R4");
    hit_rd(32'h0040_0123, 0, 0, 32'h0300_0123, "R4");
    hit_rd(32'h0045_0000, 1, 1, 32'h0205_0000, "R4");
    hit_rd(32'h0040_0123, 0, 1, 32'h0200_0123, "R5");

    // R7: demap removes the winner only
    maint(0, 0, 1, 32'h0040_0123, 0, 0, 0, 0, 0, 0, 0, 0);
    hit_rd(32'h0040_0123, 0, 0, 32'h0300_0123, "R7");
    miss(32'h0045_0000, "R7");

    // R6: non-global flush keeps the global page
    put(32'h0040_0000, 32'h0200_0000, 5'd21, 0, 0, 1, 1);
    maint(0, 1, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    miss(32'h0001_0abc, "R6");
    hit_rd(32'h0040_0123, 0, 1, 32'h0200_0123, "R6");
    maint(1, 0, 0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    miss(32'h0040_0123, "R6");

    // R3: fill all slots, then evict by recency
    for (int k = 0; k < N; k++)
      put(32'h0010_0000 + k * 32'h1000, 32'h0090_0000 + k * 32'h1000, 5'd12, 1, 1, 0, 0);
    for (int k = 0; k < N; k++)
      hit_rd(32'h0010_0044 + k * 32'h1000, 0, 0, 32'h0090_0044 + k * 32'h1000, "R3");
    hit_rd(32'h0010_0044, 1, 0, 32'h0090_0044, "R4");
    put(32'h0020_0000, 32'h00a0_0000, 5'd12, 1, 1, 0, 0);
    miss(32'h0010_1044, "R3");
    hit_rd(32'h0010_0044, 0, 0, 32'h0090_0044, "R3");
    hit_rd(32'h0020_0044, 0, 0, 32'h00a0_0044, "R3");
    hit_rd(32'h0010_2044, 0, 0, 32'h0090_2044, "R4");
    put(32'h0021_0000, 32'h00a1_0000, 5'd12, 1, 1, 0, 0);
    miss(32'h0010_2044, "R3");
    hit_rd(32'h0010_3044, 0, 0, 32'h0090_3044, "R3");

    // R10: priority between simultaneous strobes
    maint(0, 0, 1, 32'h0010_3044, 1, 32'h0031_0000, 32'h00b1_0000, 5'd12, 1, 1, 0, 0);
    miss(32'h0010_3044, "R10");
    miss(32'h0031_0044, "R10");
    hit_rd(32'h0010_4044, 0, 0, 32'h0090_4044, "R10");
    maint(0, 1, 0, 32'h0, 1, 32'h0032_0000, 32'h00b2_0000, 5'd12, 1, 1, 1, 0);
    miss(32'h0032_0044, "R10");
    miss(32'h0010_4044, "R6");
    put(32'h0033_0000, 32'h00b3_0000, 5'd12, 1, 1, 0, 0);
    maint(1, 0, 0, 32'h0, 1, 32'h0030_0000, 32'h00b0_0000, 5'd12, 1, 1, 0, 0);
    miss(32'h0030_0044, "R10");
    miss(32'h0033_0044, "R10");

    // R11: held response
    put(32'h0050_0000, 32'h0070_0000, 5'd12, 1, 1, 0, 0);
    rsp_ready = 0;
    hit_rd(32'h0050_0010, 0, 0, 32'h0070_0010, "R11");
    @(negedge clk);
    chk(req_ready == 0, "R11", "ready while held", {31'b0, req_ready}, 32'h0);
    chk(rsp_valid == 1, "R11", "valid while held", {31'b0, rsp_valid}, 32'h1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(rsp_pa == 32'h0070_0010, "R11", "held pa", rsp_pa, 32'h0070_0010);
    @(posedge clk); #1;
    rsp_ready = 1;

    repeat (4) @(posedge clk);
    #1 chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule